// File: doc/BRIEF.md
# Write-Only I2C Command Target

This block is an I2C target that lives on a fast system clock. It receives write transactions from a bus controller and turns each complete write into one 16-bit command word for a downstream register bank. SCL and SDA are brought in through a two-flop synchronizer. All edge and bus-condition detection runs on the synchronized copies.

A complete write has three bytes, and each byte is followed by an acknowledge clock. The first byte carries a 7-bit address and a direction bit. The second byte becomes the upper half of the command word and the third byte becomes the lower half. The word is handed over on the 26th SCL rising edge of the frame. A transaction that is cut short before that edge leaves the downstream registers untouched. The target never stretches the clock, never answers reads and never drives data onto the bus. Its only bus output is an active-high enable that pulls SDA low.

The controller is a state machine with seven states:
- `ST_IDLE` waits for a START.
- `ST_ADDR` shifts in the address byte.
- `ST_ADDR_ACK`, `ST_HI_ACK` and `ST_LO_ACK` hold the acknowledge through the ninth clock of each byte.
- `ST_HI` and `ST_LO` shift in the two data bytes.

The transitions are:
- START moves the machine from any state to `ST_ADDR`.
- A STOP that is honoured moves it from any state to `ST_IDLE`.
- `ST_ADDR` goes to `ST_ADDR_ACK` on the eighth-bit SCL fall when the address matches. It goes to `ST_IDLE` otherwise.
- Each acknowledge state advances on the ninth-clock SCL fall:
  - `ST_ADDR_ACK` goes to `ST_HI`.
  - `ST_HI_ACK` goes to `ST_LO`.
  - `ST_LO_ACK` goes to `ST_IDLE`.
- `ST_HI` goes to `ST_HI_ACK`, and `ST_LO` goes to `ST_LO_ACK`, on the eighth-bit SCL fall.

Top module: `wct_target`

## Requirements
- R1: While reset is asserted, and directly after it, `sda_pull` and `cmd_valid` are 0 and `cmd_word` is 0.
- R2: An address byte is acknowledged only when its seven upper bits, MSB first, equal 0b01100 followed by `addr_strap[1]` and `addr_strap[0]`, and its direction bit (bit 0) is 0. Any other address gets no acknowledge and produces no command word.
- R3: An address byte whose direction bit is 1 is never acknowledged, and the frame that follows produces no command word.
- R4: For an accepted frame, `sda_pull` rises after the SCL fall that ends the eighth bit of each of the three bytes. It falls after the SCL fall that ends that byte's ninth clock. It is 0 at all other times.
- R5: A START is SDA falling while SCL is high. From any state it begins a new address byte, so a repeated START with no STOP in between starts a fresh write.
- R6: On the 26th SCL rising edge after a START, `cmd_valid` pulses for exactly one clock. At the same time `cmd_word` takes {second byte, third byte}, each byte MSB first, and it holds that value until the next commit.
- R7: A STOP (SDA rising while SCL is high) or a START that arrives before the 26th rising edge cancels the frame. No pulse is produced and `cmd_word` is unchanged.
- R8: A STOP that comes in the same SCL high phase as the preceding START is ignored, and the frame goes on.
- R9: Bytes clocked after the third byte of a frame are neither acknowledged nor committed until the next START.
- R10: Bus inputs reach the state machine through two synchronizer flops. `sda_pull` and `cmd_valid` respond on the third system clock edge after the bus edge that causes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as received |
| sda_in | input | 1 | Bus data line as received |
| addr_strap | input | 2 | Low two address bits |
| sda_pull | output | 1 | High to pull SDA low (acknowledge) |
| cmd_valid | output | 1 | One-cycle strobe: a new command word is ready |
| cmd_word | output | 16 | Last committed command word |

## Verification
The assertions rely on a few properties of the bus inputs:
- Each SCL phase lasts several system clocks, longer than the synchronizer delay.
- SDA changes only while SCL is low, except for deliberate START and STOP conditions.
- The controller releases SDA during every acknowledge clock.

The stimulus holds each SCL phase for eight clocks and moves SDA four clocks into the low phase. It models the bus as the controller's drive ANDed with the inverse of `sda_pull`. `addr_strap` changes only between frames.

// File: rtl/wct_pkg.sv
package wct_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_HI,
        ST_HI_ACK,
        ST_LO,
        ST_LO_ACK
    } wct_state_e;

endpackage

// File: rtl/wct_sync.sv
module wct_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    // Idle bus level is high, so every stage resets to ones.
    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= '1;
        end else begin
            stg <= {stg[STAGES-2:0], d_in};
        end
    end

    assign d_out = stg[STAGES-1];

endmodule

// File: rtl/wct_cond.sv
module wct_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_ok
);

    logic scl_q;
    logic sda_q;
    logic start_seen;
    logic stop_raw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_raw = scl_s & scl_q & ~sda_q & sda_s;

    // A START opens a window that lasts until SCL next falls. A STOP seen
    // inside that window belongs to the same high phase and is dropped.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_seen <= 1'b0;
        end else if (start_c) begin
            start_seen <= 1'b1;
        end else if (scl_fall) begin
            start_seen <= 1'b0;
        end
    end

    assign stop_ok = stop_raw & ~start_seen;

    // R8: a STOP is honoured only if SCL has fallen since the last START.
    a_r8_stop_masked: assert property (@(posedge clk) disable iff (!rst_n)
        start_c |=> !stop_ok);

endmodule

// File: rtl/wct_target.sv
module wct_target
    import wct_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter int         BYTE_W      = 8,
    parameter logic [4:0] ADDR_PREFIX = 5'b01100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_in,
    input  logic                sda_in,
    input  logic [1:0]          addr_strap,
    output logic                sda_pull,
    output logic                cmd_valid,
    output logic [2*BYTE_W-1:0] cmd_word
);

    localparam int              CNT_W     = $clog2(BYTE_W + 2);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W + 1);
    localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(BYTE_W - 1);

    logic [1:0]        sync_bus;
    logic              scl_s;
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_c;
    logic              stop_ok;
    wct_state_e        state;
    wct_state_e        state_n;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] hi_byte;
    logic              addr_hit;
    logic              byte_end;
    logic              ack_end;
    logic              commit_now;

    wct_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({scl_in, sda_in}),
        .d_out (sync_bus)
    );

    assign scl_s = sync_bus[1];
    assign sda_s = sync_bus[0];

    wct_cond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_c  (start_c),
        .stop_ok  (stop_ok)
    );

    assign addr_hit   = (shreg == BYTE_W'({ADDR_PREFIX, addr_strap, 1'b0}));
    assign byte_end   = scl_fall && (bitcnt == LAST_BIT);
    assign ack_end    = scl_fall && (bitcnt == ACK_BIT);
    assign commit_now = (state == ST_LO) && scl_rise && (bitcnt == PRE_LAST);

    // Next-state logic
    always_comb begin
        state_n = state;
        if (start_c) begin
            state_n = ST_ADDR;
        end else if (stop_ok) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     state_n = ST_IDLE;
                ST_ADDR:     if (byte_end) state_n = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (ack_end)  state_n = ST_HI;
                ST_HI:       if (byte_end) state_n = ST_HI_ACK;
                ST_HI_ACK:   if (ack_end)  state_n = ST_LO;
                ST_LO:       if (byte_end) state_n = ST_LO_ACK;
                ST_LO_ACK:   if (ack_end)  state_n = ST_IDLE;
                default:     state_n = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // Bit counter and shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt  <= '0;
            shreg   <= '0;
            hi_byte <= '0;
        end else begin
            if (start_c || ack_end) begin
                bitcnt <= '0;
            end else if (scl_rise && state != ST_IDLE) begin
                bitcnt <= bitcnt + 1'b1;
            end
            if (scl_rise && state != ST_IDLE) begin
                shreg <= {shreg[BYTE_W-2:0], sda_s};
            end
            if (state == ST_HI && byte_end) begin
                hi_byte <= shreg;
            end
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_pull  <= 1'b0;
            cmd_valid <= 1'b0;
            cmd_word  <= '0;
        end else begin
            sda_pull  <= (state_n == ST_ADDR_ACK) || (state_n == ST_HI_ACK) ||
                         (state_n == ST_LO_ACK);
            cmd_valid <= commit_now;
            if (commit_now) begin
                cmd_word <= {hi_byte, shreg[BYTE_W-2:0], sda_s};
            end
        end
    end

    // R6: the strobe lasts a single cycle.
    a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R4: the acknowledge is applied only while SCL is low.
    a_r4_pull_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_s);

    // R4: the acknowledge is released only while SCL is low.
    a_r4_pull_ends_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull) |-> !scl_s);

    // R7: an honoured STOP never produces a commit.
    a_r7_stop_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ok |=> !cmd_valid);

    // R9: an idle target with no START stays off the bus.
    a_r9_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start_c) |=> !sda_pull);

endmodule

// File: tb/test_wct_target.sv
module test_wct_target;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [1:0]  strap = 2'b10;
    logic        sda_pull;
    logic        cmd_valid;
    logic [15:0] cmd_word;
    wire         sda_line = sda_m & ~sda_pull;

    int checks = 0;
    int errors = 0;
    int n_valid = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    wct_target i_wct_target (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (scl_m),
        .sda_in     (sda_line),
        .addr_strap (strap),
        .sda_pull   (sda_pull),
        .cmd_valid  (cmd_valid),
        .cmd_word   (cmd_word)
    );

    // Behavioural reference model, updated at each bus action.
    int          m_cnt  = 0;
    bit          m_act  = 0;
    bit          m_ack  = 0;
    bit          m_hs   = 0;
    bit          m_pend = 0;
    logic [7:0]  m_sh   = '0;
    logic [7:0]  m_hi   = '0;
    logic [15:0] m_word = '0;

    task automatic model_start();
        m_act = 1; m_cnt = 0; m_ack = 0; m_hs = 1;
    endtask

    task automatic model_stop();
        if (!m_hs) begin m_act = 0; m_ack = 0; end
    endtask

    task automatic model_rise(input logic b);
        if (m_act) begin
            m_cnt++;
            if (m_cnt != 9 && m_cnt != 18 && m_cnt != 27) m_sh = {m_sh[6:0], b};
            if (m_cnt == 8 && m_sh != {5'b01100, strap, 1'b0}) m_act = 0;
            if (m_cnt == 17) m_hi = m_sh;
            if (m_cnt == 26) begin m_word = {m_hi, m_sh}; m_pend = 1; end
        end
    endtask

    task automatic model_fall();
        m_hs = 0;
        if (m_act) begin
            if (m_cnt == 8 || m_cnt == 17 || m_cnt == 26) m_ack = 1;
            else if (m_cnt == 9 || m_cnt == 18 || m_cnt == 27) m_ack = 0;
            if (m_cnt == 27) m_act = 0;
        end
    endtask

    // R10: three-edge latency pipeline, compared every clock.
    bit          p_ack [3] = '{0, 0, 0};
    bit          p_v   [3] = '{0, 0, 0};
    logic [15:0] p_w   [3] = '{16'h0, 16'h0, 16'h0};

    always @(negedge clk) begin
        bit          e_ack;
        bit          e_v;
        logic [15:0] e_w;
        e_ack = p_ack[2]; e_v = p_v[2]; e_w = p_w[2];
        p_ack[2] = p_ack[1]; p_ack[1] = p_ack[0]; p_ack[0] = m_ack;
        p_v[2]   = p_v[1];   p_v[1]   = p_v[0];   p_v[0]   = m_pend;
        p_w[2]   = p_w[1];   p_w[1]   = p_w[0];   p_w[0]   = m_word;
        m_pend = 0;
        if (rst_n) begin
            if (cmd_valid) n_valid++;
            checks += 3;
            if (sda_pull !== e_ack) begin
                errors++;
                $display("FAIL R4 R10 sda_pull got %0b exp %0b at %0t", sda_pull, e_ack, $time);
            end
            if (cmd_valid !== e_v) begin
                errors++;
                $display("FAIL R6 R10 cmd_valid got %0b exp %0b at %0t", cmd_valid, e_v, $time);
            end
            if (cmd_word !== e_w) begin
                errors++;
                $display("FAIL R6 R7 cmd_word got %h exp %h at %0t", cmd_word, e_w, $time);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wclk(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic scl_up();
        scl_m = 1'b1; model_rise(sda_m);
    endtask

    task automatic scl_dn();
        scl_m = 1'b0; model_fall();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wclk(4); scl_up(); wclk(8); scl_dn(); wclk(4);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        send_bit(1'b1);
    endtask

    task automatic send_part(input logic [7:0] v, input int nb);
        for (int i = 7; i > 7 - nb; i--) send_bit(v[i]);
    endtask

    task automatic bus_start();
        if (scl_m == 1'b0) begin
            sda_m = 1'b1; wclk(4); scl_up(); wclk(4);
        end
        sda_m = 1'b0; model_start(); wclk(4);
        scl_dn(); wclk(4);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wclk(4); scl_up(); wclk(4);
        sda_m = 1'b1; model_stop(); wclk(8);
    endtask

    task automatic chk_words(input int exp_n, input logic [15:0] exp_w, input string tag);
        wclk(6);
        checks++;
        if (n_valid != exp_n || cmd_word !== exp_w) begin
            errors++;
            $display("FAIL %s words %0d word %h exp words %0d word %h",
                     tag, n_valid, cmd_word, exp_n, exp_w);
        end
    endtask

    initial begin
        wclk(3);
        checks++;
        if (sda_pull !== 1'b0 || cmd_valid !== 1'b0 || cmd_word !== 16'h0) begin
            errors++;
            $display("FAIL R1 reset outputs %b %b %h exp 0 0 0000", sda_pull, cmd_valid, cmd_word);
        end
        rst_n = 1'b1;
        wclk(5);
        checks++;
        if (sda_pull !== 1'b0 || cmd_valid !== 1'b0 || cmd_word !== 16'h0) begin
            errors++;
            $display("FAIL R1 after reset %b %b %h exp 0 0 0000", sda_pull, cmd_valid, cmd_word);
        end

        // R2 R6: strap 10 gives address byte 0x64
        bus_start(); send_byte(8'h64); send_byte(8'h4B); send_byte(8'hA5); bus_stop();
        chk_words(1, 16'h4BA5, "R6");

        // R2: strap 01 gives address byte 0x62
        strap = 2'b01; wclk(2);
        bus_start(); send_byte(8'h62); send_byte(8'h8C); send_byte(8'h3E); bus_stop();
        chk_words(2, 16'h8C3E, "R2");

        // R2: old address no longer matches
        bus_start(); send_byte(8'h64); send_byte(8'h12); send_byte(8'h34); bus_stop();
        chk_words(2, 16'h8C3E, "R2");

        // R3: read direction is refused
        bus_start(); send_byte(8'h63); send_byte(8'h55); send_byte(8'h66); bus_stop();
        chk_words(2, 16'h8C3E, "R3");

        // R7: STOP after 24 rises (its own rise is the 25th): no commit
        bus_start(); send_byte(8'h62); send_byte(8'h11); send_part(8'h22, 6); bus_stop();
        chk_words(2, 16'h8C3E, "R7");

        // R5: repeated START between two full writes
        bus_start(); send_byte(8'h62); send_byte(8'h01); send_byte(8'h23);
        bus_start(); send_byte(8'h62); send_byte(8'h45); send_byte(8'h67); bus_stop();
        chk_words(4, 16'h4567, "R5");

        // R5 R7: repeated START in mid-frame cancels, then a full write
        bus_start(); send_byte(8'h62); send_byte(8'h70);
        bus_start(); send_byte(8'h62); send_byte(8'h0F); send_byte(8'hF0); bus_stop();
        chk_words(5, 16'h0FF0, "R7");

        // R8: STOP in the same high phase as START is ignored
        sda_m = 1'b0; model_start(); wclk(4);
        sda_m = 1'b1; model_stop(); wclk(4);
        scl_dn(); wclk(4);
        send_byte(8'h62); send_byte(8'h13); send_byte(8'h57); bus_stop();
        chk_words(6, 16'h1357, "R8");

        // R9: a fourth byte gets no acknowledge and no commit
        bus_start(); send_byte(8'h62); send_byte(8'h24); send_byte(8'h68);
        send_byte(8'hFF); bus_stop();
        chk_words(7, 16'h2468, "R9");

        wclk(10);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule